// File: doc/BRIEF.md
# ECC Partial-Write Merge Sequencer

This block sits on the write path in front of a memory that stores each 64-bit word together with 8 check bits of a single-error-correcting, double-error-detecting code. It takes one write request at a time. Each request carries a word address, 64 bits of data and a byte-enable mask. A full-mask write goes to memory on the next cycle, with check bits computed over the new word. When the mask enables only some bytes, the block reads the stored word and corrects a single flipped bit in it. It then replaces the enabled bytes, computes check bits over the whole merged word and writes that word back. While this sequence runs, no other request can start. An empty mask finishes at once and touches no memory.

The memory side is a plain synchronous port. A read strobe asks for one word, and the data and check bits arrive a fixed number of cycles later. A write strobe stores a data word and its check bits. A completion pulse ends every request. That pulse carries a flag that is set when the stored word read for a merge held an error that could not be corrected.

Top module: `ecc_rmw_seq`

## Requirements
- R1: A request with `req_be` all ones, accepted at clock edge T, drives `mem_wr_en` high in cycle T+1 with `req_addr` and `req_data` on the memory port and `cpl_valid` high. There is no read, `req_ready` stays high, and a further request can be accepted in cycle T+1.
- R2: A request with `req_be` all zeros, accepted at edge T, raises `cpl_valid` in cycle T+1 with `cpl_dbl_err` low. There is no read and no write.
- R3: Any other mask, accepted at edge T, drives `mem_rd_en` high for exactly cycle T+1 with the request address. `mem_rdata`/`mem_rchk` are taken RD_LAT cycles after that read cycle. `req_ready` is low from cycle T+1 through cycle T+3+RD_LAT.
- R4: For such a partial request, `mem_wr_en` is high in cycle T+3+RD_LAT at the same address. Byte b of `mem_wdata` (bits 8b+7 down to 8b) is the request byte when `req_be[b]` is 1, and the byte of the old stored word otherwise.
- R5: The check bits written with every word are computed over the full written word, as follows. Data bits 0..63 fill codeword positions 3,5,6,7,9,... in ascending order, skipping powers of two. Check bit p (p = 0..6) is the XOR of the data bits whose position has bit p set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R6: A single flipped bit in the read word, whether in a data bit, a check bit or bit 7, is corrected before the merge.
- R7: If the read word has two flipped bits, the write still occurs and the enabled bytes are still the request bytes. `cpl_dbl_err` is high together with the completion pulse. In every other case `cpl_dbl_err` is low.
- R8: A partial request raises `cpl_valid` for exactly cycle T+4+RD_LAT, and `req_ready` is high again in that cycle.
- R9: A request presented while `req_ready` is low is not taken and not lost. It is accepted in the first cycle in which `req_ready` is high.
- R10: During reset `req_ready` is high and `mem_rd_en`, `mem_wr_en` and `cpl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request taken on an edge where valid and ready are both high |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit b for bits 8b+7:8b |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data to store |
| mem_wchk | output | CHK_W | Check bits to store |
| mem_rdata | input | DATA_W | Read data, RD_LAT cycles after the read strobe |
| mem_rchk | input | CHK_W | Read check bits, same timing as the read data |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_dbl_err | output | 1 | Uncorrectable error in the merged old word |

## Verification
A request taken at edge T finishes a set number of cycles later. A full-mask write and an empty-mask request finish in cycle T+1. A partial write reads in T+1, takes the returned word RD_LAT cycles later, writes in T+3+RD_LAT and completes in T+4+RD_LAT. When the bench accepts a request, it enters each of these events in a table indexed by cycle number. Every cycle, it samples all outputs at the falling edge and compares them with that table, so an event one cycle early or late fails just as a wrong value does. The bench memory model answers reads exactly RD_LAT cycles after the strobe it sees. It applies chosen bit flips to the answer and computes the expected merged word and error flag from its own copy of the stored data.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_MERGE,
      ST_WRITE,
      ST_DONE
   } seq_state_t;

   // number of Hamming bits (without the overall parity bit) for n data bits
   function automatic int ham_width(input int n);
      int p;
      p = 1;
      while ((1 << p) < n + p + 1) p++;
      return p;
   endfunction

   // codeword position of data bit idx: positions that are powers of two hold check bits
   function automatic int data_pos(input int idx);
      int pos;
      int seen;
      pos  = 2;
      seen = -1;
      while (seen < idx) begin
         pos++;
         if ((pos & (pos - 1)) != 0) seen++;
      end
      return pos;
   endfunction

endpackage

// File: rtl/ecc_rmw_enc.sv
module ecc_rmw_enc #(
   parameter  int DATA_W = 64,
   localparam int HAM_W  = ecc_rmw_pkg::ham_width(DATA_W),
   localparam int CHK_W  = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   logic [HAM_W-1:0] term [DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_term
      localparam int POS = ecc_rmw_pkg::data_pos(i);
      assign term[i] = data_i[i] ? HAM_W'(POS) : '0;
   end

   always_comb begin
      logic [HAM_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < DATA_W; i++) acc ^= term[i];
      chk_o = {(^data_i) ^ (^acc), acc};
   end

endmodule

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec #(
   parameter  int DATA_W = 64,
   localparam int HAM_W  = ecc_rmw_pkg::ham_width(DATA_W),
   localparam int CHK_W  = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [DATA_W-1:0] data_o,
   output logic              dbl_err_o
);

   logic [CHK_W-1:0] recomp;
   logic [HAM_W-1:0] syn;
   logic             par_bad;

   ecc_rmw_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (data_i),
      .chk_o  (recomp)
   );

   assign syn     = recomp[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
   // total parity of the received codeword, rebuilt from the recomputed bits
   assign par_bad = recomp[HAM_W] ^ chk_i[HAM_W] ^ (^syn);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int POS = ecc_rmw_pkg::data_pos(i);
      assign data_o[i] = data_i[i] ^ (par_bad && (syn == HAM_W'(POS)));
   end

   assign dbl_err_o = !par_bad && (syn != '0);

endmodule

// File: rtl/ecc_rmw_merge.sv
module ecc_rmw_merge #(
   parameter  int DATA_W = 64,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] new_i,
   input  logic [BE_W-1:0]   be_i,
   output logic [DATA_W-1:0] merged_o
);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign merged_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
   end

endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq #(
   parameter  int DATA_W = 64,
   parameter  int ADDR_W = 16,
   parameter  int RD_LAT = 2,
   localparam int BE_W   = DATA_W / 8,
   localparam int CHK_W  = ecc_rmw_pkg::ham_width(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [BE_W-1:0]   req_be,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wchk,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rchk,
   output logic              cpl_valid,
   output logic              cpl_dbl_err
);
   import ecc_rmw_pkg::*;

   localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("ecc_rmw_seq: DATA_W must be a whole number of bytes");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("ecc_rmw_seq: RD_LAT must be at least 1");
   end

   seq_state_t        st_q, st_d;
   logic [CNT_W-1:0]  wait_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] new_q, old_q, wdata_q;
   logic [BE_W-1:0]   be_q;
   logic [CHK_W-1:0]  wchk_q;
   logic              dbe_hold_q, wr_q, cpl_q, cpl_dbe_q;

   logic              accept, acc_full, acc_none, acc_part, wait_last;
   logic [DATA_W-1:0] dec_data, merged, enc_in;
   logic [CHK_W-1:0]  enc_chk;
   logic              dec_dbe;

   assign req_ready = (st_q == ST_IDLE) || (st_q == ST_DONE);
   assign accept    = req_valid && req_ready;
   assign acc_full  = accept && (&req_be);
   assign acc_none  = accept && !(|req_be);
   assign acc_part  = accept && !(&req_be) && (|req_be);
   assign wait_last = (wait_q == CNT_W'(RD_LAT - 1));

   ecc_rmw_dec #(.DATA_W(DATA_W)) u_dec (
      .data_i    (mem_rdata),
      .chk_i     (mem_rchk),
      .data_o    (dec_data),
      .dbl_err_o (dec_dbe)
   );

   ecc_rmw_merge #(.DATA_W(DATA_W)) u_merge (
      .old_i    (old_q),
      .new_i    (new_q),
      .be_i     (be_q),
      .merged_o (merged)
   );

   // one encoder shared by the pass-through path and the merge path
   assign enc_in = (st_q == ST_MERGE) ? merged : req_data;

   ecc_rmw_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_in),
      .chk_o  (enc_chk)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: st_d = acc_part ? ST_RD_ISSUE : ST_IDLE;
         ST_RD_ISSUE:      st_d = ST_RD_WAIT;
         ST_RD_WAIT:       st_d = wait_last ? ST_MERGE : ST_RD_WAIT;
         ST_MERGE:         st_d = ST_WRITE;
         ST_WRITE:         st_d = ST_DONE;
         default:          st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         wait_q     <= '0;
         addr_q     <= '0;
         new_q      <= '0;
         be_q       <= '0;
         old_q      <= '0;
         dbe_hold_q <= 1'b0;
         wdata_q    <= '0;
         wchk_q     <= '0;
         wr_q       <= 1'b0;
         cpl_q      <= 1'b0;
         cpl_dbe_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RD_ISSUE)     wait_q <= '0;
         else if (st_q == ST_RD_WAIT) wait_q <= wait_q + 1'b1;
         if (accept) begin
            addr_q <= req_addr;
            new_q  <= req_data;
            be_q   <= req_be;
         end
         if (st_q == ST_RD_WAIT && wait_last) begin
            old_q      <= dec_data;
            dbe_hold_q <= dec_dbe;
         end
         if (acc_full || st_q == ST_MERGE) begin
            wdata_q <= enc_in;
            wchk_q  <= enc_chk;
         end
         wr_q      <= acc_full || (st_q == ST_MERGE);
         cpl_q     <= acc_full || acc_none || (st_q == ST_WRITE);
         cpl_dbe_q <= (st_q == ST_WRITE) && dbe_hold_q;
      end
   end

   assign mem_rd_en   = (st_q == ST_RD_ISSUE);
   assign mem_wr_en   = wr_q;
   assign mem_addr    = addr_q;
   assign mem_wdata   = wdata_q;
   assign mem_wchk    = wchk_q;
   assign cpl_valid   = cpl_q;
   assign cpl_dbl_err = cpl_dbe_q;

   // full-mask write goes out on the next cycle, without a read
   assert_full_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (&req_be)) |=> (mem_wr_en && !mem_rd_en && cpl_valid));

   assert_empty_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(|req_be)) |=> (!mem_wr_en && !mem_rd_en && cpl_valid));

   assert_rd_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   assert_busy_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);

   // merge write-back is followed by the completion pulse with ready back
   assert_merge_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && !req_ready) |=> (cpl_valid && req_ready));

   assert_dbe_with_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_dbl_err |-> cpl_valid);

endmodule

// File: tb/sim_ecc_rmw_seq.sv
module sim_ecc_rmw_seq;
   localparam int DW  = 64;
   localparam int AW  = 16;
   localparam int LAT = 2;
   localparam int BW  = 8;
   localparam int CW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [BW-1:0] req_be = '0;
   logic          mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] mem_wchk;
   logic [DW-1:0] mem_rdata = '0;
   logic [CW-1:0] mem_rchk = '0;
   logic          cpl_valid, cpl_dbl_err;

   always #5 clk = ~clk;

   ecc_rmw_seq #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT)) u0 (
      .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_data, .req_be,
      .mem_rd_en, .mem_wr_en, .mem_addr, .mem_wdata, .mem_wchk,
      .mem_rdata, .mem_rchk, .cpl_valid, .cpl_dbl_err
   );

   typedef struct {
      int            gap;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [BW-1:0] be;
      logic [71:0]   flip;
      string         tag;
   } req_t;

   req_t          rq[$];
   logic [71:0]   mem[int];
   logic [71:0]   ret[int];
   logic [AW-1:0] e_rd_addr[int];
   logic [AW-1:0] e_wr_addr[int];
   logic [DW-1:0] e_wr_data[int];
   logic [DW-1:0] e_wr_mask[int];
   string         e_wr_tag[int];
   logic          e_cpl_dbe[int];
   string         e_cpl_tag[int];

   int          n_chk = 0, n_fail = 0;
   int          cyc = 0, busy_until = -1, last_evt = 0, gap_cnt = 0;
   logic [71:0] cur_flip = '0;

   function automatic logic [7:0] enc(input logic [63:0] d);
      logic [7:0] c;
      int pos;
      c = '0;
      pos = 3;
      for (int i = 0; i < 64; i++) begin
         while ((pos & (pos - 1)) == 0) pos++;
         for (int p = 0; p < 7; p++) if (pos[p]) c[p] = c[p] ^ d[i];
         pos++;
      end
      c[7] = (^d) ^ (^c[6:0]);
      return c;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
      end
   endtask

   function automatic void sched(input int t, input req_t r);
      logic [DW-1:0] old, mrg, msk;
      bit dbe;
      if (&r.be) begin
         e_wr_addr[t+1] = r.addr; e_wr_data[t+1] = r.data; e_wr_mask[t+1] = '1;
         e_wr_tag[t+1] = {"R1 ", r.tag};
         e_cpl_dbe[t+1] = 1'b0; e_cpl_tag[t+1] = {"R1 ", r.tag};
         if (t + 1 > last_evt) last_evt = t + 1;
      end else if (r.be == '0) begin
         e_cpl_dbe[t+1] = 1'b0; e_cpl_tag[t+1] = {"R2 ", r.tag};
         if (t + 1 > last_evt) last_evt = t + 1;
      end else begin
         old = mem.exists(int'(r.addr)) ? mem[int'(r.addr)][63:0] : '0;
         dbe = ($countones(r.flip) == 2);
         for (int b = 0; b < BW; b++) begin
            mrg[8*b +: 8] = r.be[b] ? r.data[8*b +: 8] : old[8*b +: 8];
            msk[8*b +: 8] = (r.be[b] || !dbe) ? 8'hFF : 8'h00;
         end
         e_rd_addr[t+1] = r.addr;
         e_wr_addr[t+3+LAT] = r.addr; e_wr_data[t+3+LAT] = mrg; e_wr_mask[t+3+LAT] = msk;
         e_wr_tag[t+3+LAT] = {"R4 ", r.tag};
         e_cpl_dbe[t+4+LAT] = dbe; e_cpl_tag[t+4+LAT] = {"R8 ", r.tag};
         busy_until = t + 3 + LAT;
         last_evt = t + 4 + LAT;
         cur_flip = r.flip;
      end
   endfunction

   task automatic step();
      bit e;
      // compare outputs for this cycle
      chk(req_ready === (cyc > busy_until), "R9", "req_ready", 72'(req_ready), 72'(cyc > busy_until));
      e = e_rd_addr.exists(cyc);
      chk(mem_rd_en === e, "R3", "mem_rd_en", 72'(mem_rd_en), 72'(e));
      if (e && mem_rd_en) chk(mem_addr === e_rd_addr[cyc], "R3", "read addr", 72'(mem_addr), 72'(e_rd_addr[cyc]));
      e = e_wr_addr.exists(cyc);
      chk(mem_wr_en === e, e ? e_wr_tag[cyc] : "R3", "mem_wr_en", 72'(mem_wr_en), 72'(e));
      if (e && mem_wr_en) begin
         chk(mem_addr === e_wr_addr[cyc], e_wr_tag[cyc], "write addr", 72'(mem_addr), 72'(e_wr_addr[cyc]));
         chk(((mem_wdata ^ e_wr_data[cyc]) & e_wr_mask[cyc]) == '0, e_wr_tag[cyc], "write data",
             72'(mem_wdata), 72'(e_wr_data[cyc]));
         chk(mem_wchk === enc(mem_wdata), "R5", "check bits", 72'(mem_wchk), 72'(enc(mem_wdata)));
      end
      e = e_cpl_dbe.exists(cyc);
      chk(cpl_valid === e, e ? e_cpl_tag[cyc] : "R8", "cpl_valid", 72'(cpl_valid), 72'(e));
      if (e) chk(cpl_dbl_err === e_cpl_dbe[cyc], {"R7 ", e_cpl_tag[cyc]}, "cpl_dbl_err",
                 72'(cpl_dbl_err), 72'(e_cpl_dbe[cyc]));
      else   chk(cpl_dbl_err === 1'b0, "R7", "cpl_dbl_err idle", 72'(cpl_dbl_err), 72'(0));
      // memory model
      if (mem_wr_en) mem[int'(mem_addr)] = {mem_wchk, mem_wdata};
      if (mem_rd_en) ret[cyc + LAT] = (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 72'h0) ^ cur_flip;
      if (ret.exists(cyc)) {mem_rchk, mem_rdata} = ret[cyc];
      else                 {mem_rchk, mem_rdata} = {8'hA5, 64'hDEAD_BEEF_0BAD_F00D};
      // stimulus
      if (rq.size() > 0) begin
         if (gap_cnt < rq[0].gap) begin
            req_valid = 1'b0;
            gap_cnt++;
         end else begin
            req_valid = 1'b1;
            req_addr = rq[0].addr; req_data = rq[0].data; req_be = rq[0].be;
            if (req_ready) begin
               sched(cyc, rq[0]);
               void'(rq.pop_front());
               gap_cnt = 0;
            end
         end
      end else begin
         req_valid = 1'b0;
      end
   endtask

   function automatic req_t mk(input int gap, input int addr, input logic [63:0] d,
                               input logic [7:0] be, input logic [71:0] flip, input string tag);
      req_t r;
      r.gap = gap; r.addr = AW'(addr); r.data = d; r.be = be; r.flip = flip; r.tag = tag;
      return r;
   endfunction

   initial begin
      logic [63:0] d;
      for (int a = 1; a <= 8; a++) begin
         d = {32'hC0DE_0000 + 32'(a), 32'h5A5A_1000 ^ 32'(a * 7)};
         mem[a] = {enc(d), d};
      end
      rq.push_back(mk(2, 1, 64'h1122_3344_5566_7788, 8'hFF, '0, "full write"));
      rq.push_back(mk(1, 2, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF, '0, "back-to-back 1"));
      rq.push_back(mk(0, 3, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF, '0, "back-to-back 2"));
      rq.push_back(mk(3, 4, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, '0, "empty mask"));
      rq.push_back(mk(2, 1, 64'h9999_8888_7777_6666, 8'h0F, '0, "partial clean"));
      rq.push_back(mk(2, 5, 64'h1357_9BDF_2468_ACE0, 8'h81, 72'(1) << 20, "R6 data flip"));
      rq.push_back(mk(2, 6, 64'hFEDC_BA98_7654_3210, 8'h10, 72'(1) << 67, "R6 check flip"));
      rq.push_back(mk(2, 7, 64'h0102_0304_0506_0708, 8'h02, 72'(1) << 71, "R6 overall flip"));
      rq.push_back(mk(2, 8, 64'hDDDD_EEEE_FFFF_0000, 8'h3C, (72'(1) << 5) | (72'(1) << 40), "R7 double"));
      rq.push_back(mk(2, 2, 64'h4444_5555_6666_7777, 8'h01, '0, "low byte"));
      rq.push_back(mk(0, 3, 64'h8888_9999_AAAA_BBBB, 8'hFE, '0, "R9 held partial"));
      rq.push_back(mk(0, 4, 64'hCAFE_F00D_1234_5678, 8'hFF, '0, "R9 held full"));
      rq.push_back(mk(1, 8, 64'h7777_0000_7777_0000, 8'hC0, '0, "after double"));

      // R10: reset state
      repeat (3) begin
         @(negedge clk);
         chk(req_ready === 1'b1, "R10", "ready in reset", 72'(req_ready), 72'(1));
         chk(mem_rd_en === 1'b0, "R10", "rd in reset", 72'(mem_rd_en), 72'(0));
         chk(mem_wr_en === 1'b0, "R10", "wr in reset", 72'(mem_wr_en), 72'(0));
         chk(cpl_valid === 1'b0, "R10", "cpl in reset", 72'(cpl_valid), 72'(0));
      end
      rst_n = 1'b1;
      while (rq.size() > 0 || cyc <= last_evt + 3) begin
         step();
         cyc++;
         if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
            break;
         end
         @(negedge clk);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule